// File: doc/BRIEF.md
# Byte-Lane Write Strobe Decoder

This block sits at the write side of a 32-bit synchronous SRAM. On every rising clock edge it samples the active-low write controls and turns them into four registered, active-high per-byte write strobes. The controls are a whole-word write, a gate for the per-byte selects, the four per-byte selects themselves and the processor address strobe. On the same edge it captures the input data word. In the next cycle the array stage then sees matching strobes, data and address and performs a self-timed write.

The priority is fixed. A whole-word write forces all four lanes regardless of anything else. The per-byte selects only take effect when the byte gate is low and the processor address strobe is high. When neither path yields a lane, nothing is written.

A small two-state phase machine (PH_IDLE, PH_WRITE) drives a registered any-write flag for the output-control logic, so that the output drivers are held off while a write is pending. Its transitions:
- GO_WRITE: PH_IDLE to PH_WRITE when any lane is decoded.
- STAY_WRITE: PH_WRITE to PH_WRITE when any lane is decoded.
- GO_IDLE: PH_WRITE to PH_IDLE when no lane is decoded.
- STAY_IDLE: PH_IDLE to PH_IDLE when no lane is decoded.

Top module: `sram_wr_ctl`

## Requirements
- R1: When `word_wr_n` is low at a rising edge, `lane_wr` is 4'b1111 in the following cycle, whatever the other write inputs are.
- R2: With `word_wr_n` high, `lane_gate_n` low and `addr_strobe_n` high, `lane_wr[i]` after the edge equals the inverse of `lane_sel_n[i]` sampled at that edge.
- R3: With `word_wr_n` high and `lane_gate_n` high, `lane_wr` is 4'b0000 after the edge, whatever `lane_sel_n` is.
- R4: With `word_wr_n` high and `addr_strobe_n` low, `lane_wr` is 4'b0000 after the edge, whatever `lane_sel_n` is. A low `word_wr_n` in the same cycle still writes all lanes.
- R5: Lane i covers data bits [8i+7:8i]: `lane_sel_n[0]` selects bits 7:0 and `lane_sel_n[3]` selects bits 31:24. It drives `lane_wr[0]` through `lane_wr[3]` in the same order.
- R6: `wr_word` in each cycle equals `din` sampled at the preceding rising edge.
- R7: `any_wr` is high in exactly the cycles in which `lane_wr` is non-zero.
- R8: While `rst_n` is low, `lane_wr`, `wr_word` and `any_wr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_wr_n | input | 1 | Active-low whole-word write |
| lane_gate_n | input | 1 | Active-low gate for the per-byte selects |
| lane_sel_n | input | 4 | Active-low per-byte selects, bit i for data bits [8i+7:8i] |
| addr_strobe_n | input | 1 | Active-low processor address strobe; when low it blocks byte writes |
| din | input | 32 | Write data |
| lane_wr | output | 4 | Registered active-high per-byte write strobes |
| wr_word | output | 32 | Registered write data |
| any_wr | output | 1 | Registered flag, high while any lane write is pending |

## Verification
The bench drives both priority collisions: a whole-word write together with a low address strobe or a high byte gate, which a design with the wrong priority would answer with zero or partial strobes. It also drives byte selects that are asserted while the gate is high or the strobe is low, which an ungated design would turn into spurious writes. Single-lane selects expose swapped lane order. Back-to-back writes followed by an idle cycle show a flag that lags, sticks or falls at the wrong time. Changing data every cycle shows a data register that is transparent or a cycle late.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
    localparam int unsigned LANES_DEF  = 4;
    localparam int unsigned LANE_W_DEF = 8;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_WRITE = 1'b1
    } wr_phase_e;
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
    parameter int unsigned LANES = sram_wr_pkg::LANES_DEF
) (
    input  logic             word_wr_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             addr_strobe_n,
    output logic [LANES-1:0] lane_req
);
    logic lanes_open;

    always_comb begin
        lanes_open = !lane_gate_n && addr_strobe_n;
        if (!word_wr_n) begin
            lane_req = '1;
        end else if (lanes_open) begin
            lane_req = ~lane_sel_n;
        end else begin
            lane_req = '0;
        end
    end
endmodule

// File: rtl/sram_wr_lane_reg.sv
module sram_wr_lane_reg #(
    parameter int unsigned LANES  = sram_wr_pkg::LANES_DEF,
    parameter int unsigned LANE_W = sram_wr_pkg::LANE_W_DEF,
    localparam int unsigned WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_req,
    input  logic [WORD_W-1:0] din,
    output logic [LANES-1:0]  lane_wr,
    output logic [WORD_W-1:0] wr_word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_wr[g]                   <= 1'b0;
                wr_word[g*LANE_W +: LANE_W]  <= '0;
            end else begin
                lane_wr[g]                   <= lane_req[g];
                wr_word[g*LANE_W +: LANE_W]  <= din[g*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/sram_wr_phase_fsm.sv
module sram_wr_phase_fsm
    import sram_wr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    output logic any_wr
);
    wr_phase_e phase_q, phase_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  phase_d = wr_req ? PH_WRITE : PH_IDLE;
            PH_WRITE: phase_d = wr_req ? PH_WRITE : PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    always_comb begin
        unique case (phase_q)
            PH_IDLE:  any_wr = 1'b0;
            PH_WRITE: any_wr = 1'b1;
            default:  any_wr = 1'b0;
        endcase
    end

    AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> any_wr); // R7
    AST_FLAG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> !any_wr); // R7
endmodule

// File: rtl/sram_wr_ctl.sv
module sram_wr_ctl #(
    parameter int unsigned LANES  = sram_wr_pkg::LANES_DEF,
    parameter int unsigned LANE_W = sram_wr_pkg::LANE_W_DEF,
    localparam int unsigned WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_wr_n,
    input  logic              lane_gate_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              addr_strobe_n,
    input  logic [WORD_W-1:0] din,
    output logic [LANES-1:0]  lane_wr,
    output logic [WORD_W-1:0] wr_word,
    output logic              any_wr
);
    logic [LANES-1:0] lane_req;

    sram_wr_decode #(.LANES(LANES)) u_decode (
        .word_wr_n    (word_wr_n),
        .lane_gate_n  (lane_gate_n),
        .lane_sel_n   (lane_sel_n),
        .addr_strobe_n(addr_strobe_n),
        .lane_req     (lane_req)
    );

    sram_wr_lane_reg #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_req(lane_req),
        .din     (din),
        .lane_wr (lane_wr),
        .wr_word (wr_word)
    );

    sram_wr_phase_fsm u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_req(|lane_req),
        .any_wr(any_wr)
    );

    AST_WORD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !word_wr_n |=> (lane_wr == '1)); // R1
    AST_GATE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr_n && !lane_gate_n && addr_strobe_n) |=> (lane_wr == ~$past(lane_sel_n))); // R2
    AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr_n && lane_gate_n) |=> (lane_wr == '0)); // R3
    AST_STROBE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr_n && !addr_strobe_n) |=> (lane_wr == '0)); // R4
    AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wr_word == $past(din))); // R6
    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr == (lane_wr != '0)); // R7
    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (lane_wr == '0 && wr_word == '0 && !any_wr); // R8
        end
    end
endmodule

// File: tb/sram_wr_ctl_tb.sv
module sram_wr_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        word_wr_n, lane_gate_n, addr_strobe_n;
    logic [3:0]  lane_sel_n;
    logic [31:0] din;
    logic [3:0]  lane_wr;
    logic [31:0] wr_word;
    logic        any_wr;

    int n_checks = 0;
    int n_fail   = 0;

    logic [3:0]  exp_lane;
    logic [31:0] exp_word;
    string       exp_tag;
    logic        pending = 1'b0;

    always #2.5 clk = ~clk;

    sram_wr_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .word_wr_n(word_wr_n), .lane_gate_n(lane_gate_n),
        .lane_sel_n(lane_sel_n), .addr_strobe_n(addr_strobe_n), .din(din),
        .lane_wr(lane_wr), .wr_word(wr_word), .any_wr(any_wr)
    );

    function automatic logic [3:0] model_lanes(logic w, logic g, logic [3:0] s, logic a);
        if (!w) return 4'hF;
        if (!g && a) return ~s;
        return 4'h0;
    endfunction

    function automatic string model_tag(logic w, logic g, logic a);
        if (!w) return "R1";
        if (g) return "R3";
        if (!a) return "R4";
        return "R2";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_outputs();
        if (pending) begin
            check(exp_tag, {28'd0, lane_wr}, {28'd0, exp_lane});
            check("R6", wr_word, exp_word);
            check("R7", {31'd0, any_wr}, {31'd0, exp_lane != 4'h0});
        end
    endtask

    task automatic step(logic w, logic g, logic [3:0] s, logic a, logic [31:0] d, string tag);
        @(negedge clk);
        compare_outputs();
        word_wr_n = w; lane_gate_n = g; lane_sel_n = s; addr_strobe_n = a; din = d;
        exp_lane = model_lanes(w, g, s, a);
        exp_word = d;
        exp_tag  = (tag == "") ? model_tag(w, g, a) : tag;
        pending  = 1'b1;
    endtask

    initial begin
        #100us;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        word_wr_n = 1'b1; lane_gate_n = 1'b1; lane_sel_n = 4'hF; addr_strobe_n = 1'b1;
        din = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", {27'd0, lane_wr, any_wr}, 32'd0);
        check("R8", wr_word, 32'd0);
        rst_n = 1'b1;

        // R1: whole-word write overrides a high gate and a low strobe
        step(1'b0, 1'b1, 4'hF, 1'b0, 32'h1111_2222, "R1");
        step(1'b0, 1'b0, 4'h5, 1'b1, 32'h3333_4444, "R1");
        // R5: single-lane selects, each lane in turn
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b0, ~(4'b1 << i), 1'b1, 32'hA5A5_0000 + i, "R5");
        end
        // R3: selects asserted with gate high
        step(1'b1, 1'b1, 4'h0, 1'b1, 32'h0BAD_0001, "R3");
        // R4: selects asserted with strobe low
        step(1'b1, 1'b0, 4'h0, 1'b0, 32'h0BAD_0002, "R4");
        // R2: mixed patterns
        step(1'b1, 1'b0, 4'hA, 1'b1, 32'h5555_AAAA, "R2");
        step(1'b1, 1'b0, 4'hF, 1'b1, 32'h7777_8888, "R2");
        // R7: back-to-back writes then idle
        step(1'b1, 1'b0, 4'h0, 1'b1, 32'h0000_0001, "R7");
        step(1'b0, 1'b1, 4'hF, 1'b1, 32'h0000_0002, "R7");
        step(1'b1, 1'b1, 4'hF, 1'b1, 32'h0000_0003, "R7");
        // Random mix checked against the model every cycle
        for (int k = 0; k < 400; k++) begin
            logic [7:0] r;
            r = 8'($urandom);
            step(r[0] | r[1], r[2], r[6:3], r[7] | r[1], $urandom, "");
        end
        @(negedge clk);
        compare_outputs();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule